// File: doc/BRIEF.md
# Software-Maintained Translation Buffer Array

This block is a fully associative array of page translations that software fills and maintains itself. Every entry has two word-wide halves. The tag half holds an effective page number, a valid flag and an owner ID. The data half holds a real page number and attribute bits that the array stores without interpreting them. Software reads and writes each half separately. It names the entry with an index and names the half with a select bit, so a whole entry takes two accesses.

A combinational search port takes the page number of an effective address together with the current process ID. It returns a hit flag and the index of the matching entry. Software then uses that index for later reads or writes. A single command drops every valid flag at once. A synchronize command is also accepted, and it changes nothing.

Tag-half word layout (32 bits): bits 31..10 page number, bit 9 valid, bit 8 reads as zero, bits 7..0 owner ID. On a tag write, bits 8..0 of the write word are ignored. Data-half words are stored and returned as written.

Top module: `sw_tlb_array`

## Requirements
- R1: After reset every entry is invalid. Any search misses, and a tag read returns valid bit 9 as 0.
- R2: A write with select 0 loads the page number from bits 31..10 and the valid flag from bit 9. It loads the owner ID (bits 7..0 on readback) from `cur_pid`, never from the write word.
- R3: A write with select 1 replaces the full data-half word of the indexed entry and leaves that entry's tag half unchanged.
- R4: The read port returns the tag half when `rd_sel` is 0 and the data half when it is 1, for the entry at `rd_idx`, with no clock delay.
- R5: A search hits when an entry is valid, its page number equals `srch_vpn`, and its owner ID equals `cur_pid` or is zero (a global entry). `srch_hit` is then 1 and `srch_idx` gives that entry.
- R6: An entry whose non-zero owner ID differs from `cur_pid` does not match.
- R7: When several entries match, `srch_idx` reports the lowest-numbered one.
- R8: `inv_all` clears every valid flag at the next clock edge. Any write in the same cycle is discarded.
- R9: Writing a tag half with bit 9 at 0 removes that one entry from all later searches.
- R10: A `sync_cmd` cycle leaves all entry contents unchanged.
- R11: Writes take effect at the next rising clock edge. A read of the target entry in the write cycle still returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one half of one entry |
| wr_sel | input | 1 | Half to write: 0 tag, 1 data |
| wr_idx | input | 6 | Entry to write |
| wr_data | input | 32 | Write word |
| cur_pid | input | 8 | Current process ID, used for tag writes and searches |
| inv_all | input | 1 | Clear all valid flags |
| sync_cmd | input | 1 | Synchronize command, no effect |
| rd_idx | input | 6 | Entry to read |
| rd_sel | input | 1 | Half to read: 0 tag, 1 data |
| rd_data | output | 32 | Selected half word |
| srch_vpn | input | 22 | Effective page number to look up |
| srch_hit | output | 1 | A matching entry exists |
| srch_idx | output | 6 | Index of the lowest matching entry, meaningful only on a hit |

## Verification
The bench places the same page number in several entries and checks that the lowest index wins. A design that scanned from the top would report a higher index. It writes a tag with all ones in the ID bits of the write word under a different process ID. A design that took the ID from the write word would then read back 0xFF, and its searches would go wrong. The bench sets global entries and mismatched IDs side by side, which catches a design that lets a mismatched ID hit or that loses global matching. It also issues an invalidate-all in the same cycle as a write. A design that let the write through would leave an entry that still hits afterwards.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int TLB_ENTRIES    = 64;
   localparam int TLB_WORD_W     = 32;
   localparam int TLB_EPN_W      = 22;
   localparam int TLB_TID_W      = 8;

   // Build the readback word of a tag half: page | valid | zero pad | owner
   function automatic logic [TLB_WORD_W-1:0] pack_tag(
      input logic [TLB_EPN_W-1:0] epn,
      input logic                 vld,
      input logic [TLB_TID_W-1:0] tid);
      logic [TLB_WORD_W-1:0] w;
      w = '0;
      w[TLB_WORD_W-1 -: TLB_EPN_W] = epn;
      w[TLB_TID_W+1]               = vld;
      w[TLB_TID_W-1:0]             = tid;
      return w;
   endfunction
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry #(
   parameter int WORD_W = 32,
   parameter int EPN_W  = 22,
   parameter int TID_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inv_all,
   input  logic              wr_tag,
   input  logic              wr_dat,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [TID_W-1:0]  pid,
   input  logic [EPN_W-1:0]  srch_vpn,
   output logic [WORD_W-1:0] tag_word,
   output logic [WORD_W-1:0] data_word,
   output logic              vld,
   output logic              match
);
   localparam int VBIT = TID_W + 1;

   logic [EPN_W-1:0]  epn_q;
   logic              v_q;
   logic [TID_W-1:0]  tid_q;
   logic [WORD_W-1:0] dat_q;

   // Tag half: invalidate-all wins over a same-cycle write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         epn_q <= '0;
         v_q   <= 1'b0;
         tid_q <= '0;
      end else if (inv_all) begin
         v_q   <= 1'b0;
      end else if (wr_tag) begin
         epn_q <= wr_word[WORD_W-1 -: EPN_W];
         v_q   <= wr_word[VBIT];
         tid_q <= pid;
      end
   end

   // Data half: stored verbatim
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dat_q <= '0;
      else if (wr_dat && !inv_all)
         dat_q <= wr_word;
   end

   always_comb begin
      tag_word                   = '0;
      tag_word[WORD_W-1 -: EPN_W] = epn_q;
      tag_word[VBIT]             = v_q;
      tag_word[TID_W-1:0]        = tid_q;
   end

   assign data_word = dat_q;
   assign vld       = v_q;
   assign match     = v_q && (epn_q == srch_vpn) &&
                      ((tid_q == pid) || (tid_q == '0));

   a_r8_inv_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
      $past(inv_all) |-> !v_q);
   a_r2_tid_from_pid: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_tag && !inv_all) |-> (tid_q == $past(pid)) && (v_q == $past(wr_word[VBIT])));
   a_r3_data_keeps_tag: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_dat && !wr_tag && !inv_all) |-> ($stable(epn_q) && $stable(v_q) && $stable(tid_q)));
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
   parameter int N  = 64,
   parameter int IW = 6
) (
   input  logic [N-1:0]  req,
   output logic          hit,
   output logic [IW-1:0] idx
);
   // Scan from the top down so the last assignment is the lowest index
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            hit = 1'b1;
            idx = IW'(i);
         end
      end
   end

   logic [N-1:0] below_mask;
   assign below_mask = ({{(N-1){1'b0}}, 1'b1} << idx) - 1'b1;

   always_comb begin
      if (hit) begin
         a_r7_lowest_wins: assert ((req & below_mask) == '0 && req[idx]);
      end
   end
endmodule

// File: rtl/sw_tlb_array.sv
module sw_tlb_array #(
   parameter int ENTRIES = tlb_pkg::TLB_ENTRIES,
   parameter int WORD_W  = tlb_pkg::TLB_WORD_W,
   parameter int EPN_W   = tlb_pkg::TLB_EPN_W,
   parameter int TID_W   = tlb_pkg::TLB_TID_W,
   localparam int IW     = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [IW-1:0]     wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [TID_W-1:0]  cur_pid,
   input  logic              inv_all,
   input  logic              sync_cmd,
   input  logic [IW-1:0]     rd_idx,
   input  logic              rd_sel,
   output logic [WORD_W-1:0] rd_data,
   input  logic [EPN_W-1:0]  srch_vpn,
   output logic              srch_hit,
   output logic [IW-1:0]     srch_idx
);
   localparam int SLOTS = 1 << IW;

   generate
      if (ENTRIES < 2) begin : g_bad_depth
         $error("sw_tlb_array: ENTRIES must be at least 2");
      end
      if (EPN_W + TID_W + 2 != WORD_W) begin : g_bad_layout
         $error("sw_tlb_array: tag layout does not fill WORD_W");
      end
   endgenerate

   logic [WORD_W-1:0]  tag_arr  [ENTRIES];
   logic [WORD_W-1:0]  data_arr [ENTRIES];
   logic [ENTRIES-1:0] vld_vec;
   logic [ENTRIES-1:0] match_vec;

   genvar gi;
   generate
      for (gi = 0; gi < ENTRIES; gi++) begin : g_ent
         logic sel_me;
         assign sel_me = wr_en && (wr_idx == IW'(gi));
         tlb_entry #(
            .WORD_W (WORD_W),
            .EPN_W  (EPN_W),
            .TID_W  (TID_W)
         ) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .inv_all   (inv_all),
            .wr_tag    (sel_me && !wr_sel),
            .wr_dat    (sel_me && wr_sel),
            .wr_word   (wr_data),
            .pid       (cur_pid),
            .srch_vpn  (srch_vpn),
            .tag_word  (tag_arr[gi]),
            .data_word (data_arr[gi]),
            .vld       (vld_vec[gi]),
            .match     (match_vec[gi])
         );
      end
   endgenerate

   // Read mux: direct when the index space is full, guarded otherwise
   generate
      if (ENTRIES == SLOTS) begin : g_rd_full
         always_comb rd_data = rd_sel ? data_arr[rd_idx] : tag_arr[rd_idx];
      end else begin : g_rd_part
         always_comb begin
            rd_data = '0;
            for (int i = 0; i < ENTRIES; i++)
               if (rd_idx == IW'(i))
                  rd_data = rd_sel ? data_arr[i] : tag_arr[i];
         end
      end
   endgenerate

   tlb_prio_enc #(
      .N  (ENTRIES),
      .IW (IW)
   ) u_enc (
      .req (match_vec),
      .hit (srch_hit),
      .idx (srch_idx)
   );

   a_r5_hit_is_real: assert property (@(posedge clk) disable iff (!rst_n)
      srch_hit |-> (vld_vec[srch_idx] &&
                    tag_arr[srch_idx][WORD_W-1 -: EPN_W] == srch_vpn));
   a_r10_sync_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_cmd && !wr_en && !inv_all) |=> $stable(vld_vec));
   a_r8_inv_empties: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> (vld_vec == '0));
endmodule

// File: tb/sim_sw_tlb_array.sv
module sim_sw_tlb_array;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, wr_sel, inv_all, sync_cmd, rd_sel;
   logic [5:0]  wr_idx, rd_idx;
   logic [31:0] wr_data;
   logic [7:0]  cur_pid;
   logic [31:0] rd_data;
   logic [21:0] srch_vpn;
   logic        srch_hit;
   logic [5:0]  srch_idx;

   always #4 clk = ~clk;

   sw_tlb_array u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
      .wr_data(wr_data), .cur_pid(cur_pid), .inv_all(inv_all), .sync_cmd(sync_cmd),
      .rd_idx(rd_idx), .rd_sel(rd_sel), .rd_data(rd_data), .srch_vpn(srch_vpn),
      .srch_hit(srch_hit), .srch_idx(srch_idx));

   typedef struct {
      bit          is_read;
      bit          exp_hit;
      int          exp_idx;
      logic [31:0] exp_word;
      string       req;
   } exp_t;

   exp_t sbq[$];
   int   n_chk  = 0;
   int   n_fail = 0;
   bit   finished = 0;

   // Reference model of the entries, updated one edge after each write
   logic [21:0] m_epn [64];
   logic        m_v   [64];
   logic [7:0]  m_tid [64];
   logic [31:0] m_dat [64];
   bit          p_wr, p_sel, p_inv;
   int          p_idx;
   logic [31:0] p_word;
   logic [7:0]  p_pid;

   function automatic logic [31:0] m_tagw(int i);
      return {m_epn[i], m_v[i], 1'b0, m_tid[i]};
   endfunction

   task automatic go();
      @(negedge clk);
      if (p_inv) begin
         for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
      end else if (p_wr) begin
         if (p_sel) m_dat[p_idx] = p_word;
         else begin
            m_epn[p_idx] = p_word[31:10];
            m_v[p_idx]   = p_word[9];
            m_tid[p_idx] = p_pid;
         end
      end
      p_wr = 0; p_inv = 0;
      wr_en = 0; inv_all = 0; sync_cmd = 0;
   endtask

   task automatic t_write(bit sel, int idx, logic [31:0] word, logic [7:0] p);
      go();
      wr_en = 1; wr_sel = sel; wr_idx = 6'(idx); wr_data = word; cur_pid = p;
      p_wr = 1; p_sel = sel; p_idx = idx; p_word = word; p_pid = p;
   endtask

   task automatic t_tag(int idx, logic [21:0] epn, bit v, logic [7:0] p);
      t_write(1'b0, idx, {epn, v, 9'h1FF}, p);
   endtask

   task automatic chk_read(int idx, bit sel, string req);
      exp_t e;
      rd_idx = 6'(idx); rd_sel = sel;
      e.is_read = 1; e.exp_hit = 0; e.exp_idx = 0; e.req = req;
      e.exp_word = sel ? m_dat[idx] : m_tagw(idx);
      sbq.push_back(e);
   endtask

   task automatic chk_search(logic [21:0] vpn, logic [7:0] p, string req);
      exp_t e;
      srch_vpn = vpn; cur_pid = p;
      e.is_read = 0; e.exp_hit = 0; e.exp_idx = 0; e.exp_word = '0; e.req = req;
      for (int i = 63; i >= 0; i--)
         if (m_v[i] && m_epn[i] == vpn && (m_tid[i] == p || m_tid[i] == 8'h00)) begin
            e.exp_hit = 1; e.exp_idx = i;
         end
      sbq.push_back(e);
   endtask

   // Monitor: compares queued expectations mid-cycle
   initial begin
      forever begin
         @(negedge clk);
         #3;
         while (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            n_chk++;
            if (e.is_read) begin
               if (rd_data !== e.exp_word) begin
                  n_fail++;
                  $display("FAIL %s read: got %h expected %h", e.req, rd_data, e.exp_word);
               end
            end else if (srch_hit !== e.exp_hit ||
                         (e.exp_hit && srch_idx !== 6'(e.exp_idx))) begin
               n_fail++;
               $display("FAIL %s search: got hit=%b idx=%0d expected hit=%b idx=%0d",
                        e.req, srch_hit, srch_idx, e.exp_hit, e.exp_idx);
            end
         end
      end
   end

   localparam logic [21:0] PA = 22'h2ABCD1;
   localparam logic [21:0] PB = 22'h000123;
   localparam logic [21:0] PC = 22'h3FFFFF;

   initial begin
      for (int i = 0; i < 64; i++) begin
         m_epn[i] = '0; m_v[i] = 0; m_tid[i] = '0; m_dat[i] = '0;
      end
      p_wr = 0; p_inv = 0; p_sel = 0; p_idx = 0; p_word = '0; p_pid = '0;
      rst_n = 0; wr_en = 0; wr_sel = 0; wr_idx = '0; wr_data = '0; cur_pid = '0;
      inv_all = 0; sync_cmd = 0; rd_idx = '0; rd_sel = 0; srch_vpn = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      go();
      chk_read(5, 0, "R1");
      chk_search(22'h000000, 8'h00, "R1");
      go();
      chk_search(PA, 8'h12, "R1");

      // R11: read in the write cycle sees old contents
      t_tag(3, PA, 1, 8'h12);
      chk_read(3, 0, "R11");
      go();
      chk_read(3, 0, "R2");

      t_write(1, 3, 32'hDEAD_B3EF, 8'h12);
      go();
      chk_read(3, 1, "R3");
      go();
      chk_read(3, 0, "R3");
      go();
      chk_read(3, 1, "R4");
      chk_search(PA, 8'h12, "R5");
      go();
      chk_search(PA, 8'h13, "R6");

      t_tag(10, PB, 1, 8'h00);
      go();
      chk_search(PB, 8'h55, "R5");

      t_tag(20, PC, 1, 8'h12);
      t_tag(7, PC, 1, 8'h12);
      t_tag(40, PC, 1, 8'h00);
      go();
      chk_search(PC, 8'h12, "R7");
      go();
      chk_search(PC, 8'h77, "R7");

      t_tag(7, PC, 0, 8'h12);
      go();
      chk_search(PC, 8'h12, "R9");
      chk_read(7, 0, "R9");

      go();
      sync_cmd = 1;
      go();
      chk_search(PC, 8'h12, "R10");
      chk_read(3, 1, "R10");

      // R8: invalidate-all with a same-cycle write that must be dropped
      go();
      inv_all = 1; p_inv = 1;
      wr_en = 1; wr_sel = 0; wr_idx = 6'd50; wr_data = {PB, 1'b1, 9'h000}; cur_pid = 8'h00;
      go();
      chk_search(PB, 8'h00, "R8");
      chk_read(50, 0, "R8");
      go();
      chk_search(PA, 8'h12, "R8");
      chk_read(20, 0, "R8");

      t_tag(63, PA, 1, 8'h21);
      go();
      chk_search(PA, 8'h21, "R5");
      chk_read(63, 0, "R2");
      go();
      go();

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule